// File: doc/BRIEF.md
# Sequential Multi-Pin Configuration Writer

This block takes one configuration word and writes it, unchanged, to a run of consecutive smart-pin ports. The run is described by a starting pin and a count of additional pins. It issues one pin write per clock, so the pins are updated in sequence rather than all on the same edge. Three write kinds are carried alongside the word: mode, X parameter and Y parameter. The pin port uses the kind to decide which of its registers takes the word.

The instruction pipeline presents a request with an operand word. Bits [5:0] of the operand hold the starting pin and bits [10:6] hold the extra-pin count. If the instruction just before it was the count-setting prefix, the pipeline also raises an override flag with a 5-bit count, and that count replaces the operand's count field. The pin number always stays inside the 32-pin half that holds the starting pin and wraps around within it. The pipeline watches `busy` to stall and `done` to retire the instruction.

Top module: `pin_span_writer`

## Requirements
- R1: After reset, `busy`, `done` and `pin_we` are all low.
- R2: An accepted request writes to operand[5:0] first and performs operand[10:6]+1 pin writes in total when no override is flagged.
- R3: When `req_ovr_valid` is high, `req_ovr` replaces the operand count field, so the run is `req_ovr`+1 writes. An override of 0 gives exactly one write, whatever the operand count field holds.
- R4: The first pin write happens in the cycle after the request is accepted, and one write follows per clock with no gap. The whole operation lasts N+2 cycles for N extra pins, counting the acceptance cycle.
- R5: The low five bits of the pin number increase by one per write, modulo 32. Bit 5 keeps the value of the starting pin's bit 5, so 30 is followed by 31, 0, 1 and 63 is followed by 32.
- R6: Every write in a run carries the request's data word and kind. Kind encoding: 0 = mode, 1 = X parameter, 2 = Y parameter.
- R7: A request with kind code 3 is not accepted and produces no write.
- R8: `busy` is high in exactly the cycles in which `pin_we` is high. `done` is a single-cycle pulse in the cycle after the last write.
- R9: A request presented while `busy` is high is ignored. The current run continues unchanged, and no further run follows it.
- R10: A request presented in the `done` cycle is accepted, and its first write happens in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Write kind: 0 mode, 1 X, 2 Y, 3 invalid |
| req_operand | input | 11 | [5:0] starting pin, [10:6] extra-pin count |
| req_ovr_valid | input | 1 | Prefix override present |
| req_ovr | input | 5 | Override extra-pin count |
| req_data | input | 32 | Word to write |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the last write |
| pin_we | output | 1 | Pin write strobe |
| pin_kind | output | 2 | Kind of the current write |
| pin_addr | output | 6 | Target pin number |
| pin_data | output | 32 | Word being written |

## Verification
Counting from the cycle in which a request is accepted, write k (starting at 0) appears k+1 cycles later. `done` is due N+2 cycles after acceptance, and `busy` drops in that same cycle. The bench drives each request on a falling edge and samples outputs on later falling edges. Each sample is taken at the falling edge given by this count, so each write's pin number, word and kind are compared in the exact cycle they are due. The bench then checks the following cycle to confirm that `done` has cleared and that no extra write has appeared.

// File: rtl/pin_span_writer.sv
module pin_span_writer #(
  parameter int PIN_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [1:0]              req_kind,
  input  logic [2*PIN_W-2:0]      req_operand,
  input  logic                    req_ovr_valid,
  input  logic [PIN_W-2:0]        req_ovr,
  input  logic [DATA_W-1:0]       req_data,
  output logic                    busy,
  output logic                    done,
  output logic                    pin_we,
  output logic [1:0]              pin_kind,
  output logic [PIN_W-1:0]        pin_addr,
  output logic [DATA_W-1:0]       pin_data
);
  localparam int IDX_W = PIN_W - 1;
  localparam logic [1:0] KIND_BAD = 2'd3;

  logic              active, half, done_q;
  logic [IDX_W-1:0]  idx, left;
  logic [1:0]        kind_q;
  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  span;
  logic              accept;

  assign accept = req_valid && !active && (req_kind != KIND_BAD);
  assign span   = req_ovr_valid ? req_ovr : req_operand[PIN_W +: IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      half   <= 1'b0;
      idx    <= '0;
      left   <= '0;
      kind_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= active && (left == '0);
      if (accept) begin
        active <= 1'b1;
        half   <= req_operand[PIN_W-1];
        idx    <= req_operand[IDX_W-1:0];
        left   <= span;
        kind_q <= req_kind;
        data_q <= req_data;
      end else if (active) begin
        if (left == '0) begin
          active <= 1'b0;
        end else begin
          left <= left - 1'b1;
          idx  <= idx + 1'b1;
        end
      end
    end
  end

  assign busy     = active;
  assign pin_we   = active;
  assign done     = done_q;
  assign pin_kind = kind_q;
  assign pin_addr = {half, idx};
  assign pin_data = data_q;

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_we && $past(pin_we) && !$past(done)) |->
      (pin_addr[IDX_W-1:0] == $past(pin_addr[IDX_W-1:0]) + 1'b1) &&
      (pin_addr[PIN_W-1] == $past(pin_addr[PIN_W-1])));

  a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_we && $past(pin_we)) |-> ($stable(pin_data) && $stable(pin_kind)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(pin_we) && !$past(done)));

  a_r7_no_bad_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_we) |-> ($past(req_valid) && $past(req_kind) != KIND_BAD));

  a_r9_busy_holds_run: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && !(left == '0)) |=> (busy && $stable(pin_data)));
endmodule

// File: tb/pin_span_writer_tb.sv
`timescale 1ns/1ps
module pin_span_writer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [10:0] req_operand = '0;
  logic req_ovr_valid = 1'b0;
  logic [4:0] req_ovr = '0;
  logic [31:0] req_data = '0;
  logic busy, done, pin_we;
  logic [1:0] pin_kind;
  logic [5:0] pin_addr;
  logic [31:0] pin_data;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pin_span_writer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_operand(req_operand), .req_ovr_valid(req_ovr_valid), .req_ovr(req_ovr),
    .req_data(req_data), .busy(busy), .done(done), .pin_we(pin_we),
    .pin_kind(pin_kind), .pin_addr(pin_addr), .pin_data(pin_data));

  localparam int NV = 7;
  localparam int V_KIND [NV] = '{0, 1, 2, 0, 1, 2, 0};
  localparam int V_BASE [NV] = '{5, 8, 30, 62, 40, 16, 33};
  localparam int V_SPAN [NV] = '{0, 3, 3, 2, 7, 1, 31};
  localparam int V_OVV  [NV] = '{0, 0, 0, 0, 1, 1, 0};
  localparam int V_OVR  [NV] = '{0, 0, 0, 0, 0, 5, 0};
  localparam int V_CNT  [NV] = '{1, 4, 4, 3, 1, 6, 32};

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input int kind, input int base, input int span, input int ovv,
                     input int ovr, input logic [31:0] data, input int cnt, input bit intrude);
    logic [5:0] b;
    logic [5:0] ea;
    b = 6'(base);
    req_valid = 1'b1;
    req_kind = 2'(kind);
    req_operand = {5'(span), b};
    req_ovr_valid = 1'(ovv);
    req_ovr = 5'(ovr);
    req_data = data;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < cnt; k++) begin
      ea = {b[5], 5'(b[4:0] + 5'(k))};
      if (intrude && k == 0) begin
        req_valid = 1'b1; req_kind = 2'd1; req_operand = {5'd0, 6'd20};
        req_ovr_valid = 1'b0; req_data = ~data;
      end
      if (intrude && k == 2) req_valid = 1'b0;
      chk(pin_we === 1'b1 && busy === 1'b1, "R4/R8 write strobe and busy", {30'd0, busy, pin_we}, 32'h3);
      chk(pin_addr === ea, "R2/R5 pin address", {26'd0, pin_addr}, {26'd0, ea});
      chk(pin_data === data, "R6 data word", pin_data, data);
      chk(pin_kind === 2'(kind), "R6 kind", {30'd0, pin_kind}, kind);
      chk(done === 1'b0, "R8 done low during run", {31'd0, done}, 0);
      @(negedge clk);
    end
    chk(done === 1'b1 && pin_we === 1'b0 && busy === 1'b0, "R3/R4/R8 done after last write",
        {29'd0, done, busy, pin_we}, 32'h4);
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    chk(done === 1'b0 && pin_we === 1'b0 && busy === 1'b0, tag, {29'd0, done, busy, pin_we}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && pin_we === 1'b0, "R1 reset state",
        {29'd0, done, busy, pin_we}, 0);

    for (int i = 0; i < NV; i++) begin
      run(V_KIND[i], V_BASE[i], V_SPAN[i], V_OVV[i], V_OVR[i],
          32'hA5000000 + 32'(i) * 32'h01010101, V_CNT[i], 1'b0);
      idle_check("R8 done single cycle, idle after run");
    end

    // R7: bad kind ignored
    req_valid = 1'b1; req_kind = 2'd3; req_operand = {5'd4, 6'd2}; req_data = 32'hDEAD0001;
    req_ovr_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(pin_we === 1'b0 && busy === 1'b0, "R7 kind 3 ignored", {30'd0, busy, pin_we}, 0);
    idle_check("R7 still idle");

    // R9: intruding request while busy
    run(0, 4, 3, 0, 0, 32'h12345678, 4, 1'b1);
    idle_check("R9 intruder left no run");

    // R10: back-to-back, second request in the done cycle
    run(2, 10, 1, 0, 0, 32'h0BADF00D, 2, 1'b0);
    run(1, 63, 1, 0, 0, 32'h600DCAFE, 2, 1'b0);
    idle_check("R10 idle after chained run");

    // R3: override zero with a large operand span
    run(2, 7, 31, 1, 0, 32'h77777777, 1, 1'b0);
    idle_check("R3 single write with zero override");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule